// File: doc/BRIEF.md
# Camera Line Capture Window Controller

This block watches a camera pixel interface (pixel clock, line-valid strobe, optional data-valid strobe, pixel bus) and picks out one window of pixels per line. A line begins only when line-valid goes from low to high while the line-arm input is high. The block then drops a programmable number of qualified clocks and passes through a programmable number of qualified pixels. After that it ignores the interface until line-valid rises again.

A qualified clock is any clock while the data-valid qualifier is switched off. While the qualifier is switched on, only clocks with data-valid high are qualified. Captured pixels leave the block one clock after they were presented. A valid strobe marks each one, a start-of-line marker comes with the first and an end-of-line marker with the last. A new rising edge that arrives in the middle of a window cuts that window short and starts the next one. The cut-off is signalled by an end-of-line marker. Configuration inputs must stay stable from a rising edge until the window closes.

Top module: `lineWindowCtrl`

## Requirements
- R1: A window opens only on a clock where line-valid is 1 and was 0 on the previous clock. The falling edge of line-valid has no effect: an open window keeps counting and capturing while line-valid is low.
- R2: The line-arm input is looked at only on the rising-edge clock. If it is low there, the whole line yields no pixels, even if line-arm rises later in that line.
- R3: The first `skipCnt` qualified clocks of a window, counted from the rising-edge clock inclusive, are discarded (0 to 255). With 0, the pixel presented on the rising-edge clock is the first one captured.
- R4: After the skip phase exactly `activeCnt` qualified pixels are captured. Later clocks produce no pixel until the next rising edge.
- R5: With `qualEn` = 1, a clock with data-valid low is neither captured nor counted toward the skip. With `qualEn` = 0, data-valid is ignored.
- R6: For a pixel captured on clock n, `pixValid` is 1 after edge n and `pixOut` equals the `pixData` presented on clock n.
- R7: `sol` is 1 together with the first captured pixel of a window, and `eol` is 1 together with the last.
- R8: A rising edge while a window is still skipping or capturing aborts it. `eol` is 1 on the output cycle of that edge, and a new window starts from that edge. With a nonzero skip, that output cycle has `pixValid` = 0.
- R9: With `activeCnt` = 0, a window captures no pixel and waits for the next rising edge.
- R10: A line-valid high pulse of one clock followed by a low of one clock is enough to start a window each time.
- R11: While the synchronous reset `rst` is high, `pixValid`, `sol` and `eol` are 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Camera pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| lineValid | input | 1 | Line-valid strobe from the camera |
| dataValid | input | 1 | Data-valid strobe from the camera |
| pixData | input | DATA_W | Pixel data bus |
| armEn | input | 1 | Line-arm: accept the next line |
| qualEn | input | 1 | Use data-valid to qualify clocks |
| skipCnt | input | SKIP_W | Qualified clocks to drop at line start |
| activeCnt | input | CNT_W | Pixels to capture per line |
| pixValid | output | 1 | Captured pixel strobe |
| pixOut | output | DATA_W | Captured pixel data |
| sol | output | 1 | First pixel of the window |
| eol | output | 1 | Last pixel of the window, or abort marker |

## Verification
Every output is one register stage behind the clock whose inputs caused it. A pixel, a start marker or an end marker caused by the inputs of clock n is therefore visible right after edge n. An abort marker appears right after the edge on which line-valid rose again. The bench drives each clock's inputs on the falling edge and samples the outputs 1 ns after the following rising edge. Its expected values come from counting qualified clocks from the rising edge, so every check lands on the cycle the requirement names.

// File: rtl/lwc_pkg.sv
`timescale 1ns/1ps
package lwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SKIP = 2'd1,
    ST_CAPT = 2'd2,
    ST_DONE = 2'd3
  } lwcState_t;

  // strobes from control to datapath, valid for the current clock
  typedef struct packed {
    logic capture;
    logic first;
    logic last;
    logic abort;
  } lwcStrobes_t;

endpackage

// File: rtl/lwcControl.sv
`timescale 1ns/1ps
module lwcControl
  import lwc_pkg::*;
#(
  parameter int SKIP_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lineValid,
  input  logic              dataValid,
  input  logic              armEn,
  input  logic              qualEn,
  input  logic [SKIP_W-1:0] skipCnt,
  input  logic [CNT_W-1:0]  activeCnt,
  output lwcStrobes_t       strobes
);

  localparam int CW = (SKIP_W > CNT_W) ? SKIP_W : CNT_W;

  lwcState_t state, nextState, effState;
  logic [CW-1:0] cnt, nextCnt, effCnt;
  logic lvPrev;
  logic riseNow, qualNow;
  logic [CW-1:0] skipLast, activeLast;

  assign riseNow    = lineValid & ~lvPrev;
  assign qualNow    = ~qualEn | dataValid;
  assign skipLast   = CW'(skipCnt) - CW'(1);
  assign activeLast = CW'(activeCnt) - CW'(1);

  // state as seen on this clock, after a possible rising edge
  always_comb begin
    effState      = state;
    effCnt        = cnt;
    strobes.abort = 1'b0;
    if (riseNow) begin
      strobes.abort = (state == ST_SKIP) || (state == ST_CAPT);
      effCnt        = '0;
      if (!armEn)              effState = ST_IDLE;
      else if (skipCnt != '0)  effState = ST_SKIP;
      else if (activeCnt != '0) effState = ST_CAPT;
      else                     effState = ST_DONE;
    end
  end

  always_comb begin
    nextState       = effState;
    nextCnt         = effCnt;
    strobes.capture = 1'b0;
    strobes.first   = 1'b0;
    strobes.last    = 1'b0;
    case (effState)
      ST_SKIP: begin
        if (qualNow) begin
          if (effCnt == skipLast) begin
            nextCnt   = '0;
            nextState = (activeCnt != '0) ? ST_CAPT : ST_DONE;
          end else begin
            nextCnt = effCnt + CW'(1);
          end
        end
      end
      ST_CAPT: begin
        if (qualNow) begin
          strobes.capture = 1'b1;
          strobes.first   = (effCnt == '0);
          strobes.last    = (effCnt == activeLast);
          if (effCnt == activeLast) begin
            nextCnt   = '0;
            nextState = ST_DONE;
          end else begin
            nextCnt = effCnt + CW'(1);
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      lvPrev <= 1'b0;
    end else begin
      state  <= nextState;
      cnt    <= nextCnt;
      lvPrev <= lineValid;
    end
  end

endmodule

// File: rtl/lwcDatapath.sv
`timescale 1ns/1ps
module lwcDatapath
  import lwc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  lwcStrobes_t       strobes,
  input  logic [DATA_W-1:0] pixData,
  output logic              pixValid,
  output logic [DATA_W-1:0] pixOut,
  output logic              sol,
  output logic              eol
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pixValid <= 1'b0;
      pixOut   <= '0;
      sol      <= 1'b0;
      eol      <= 1'b0;
    end else begin
      pixValid <= strobes.capture;
      sol      <= strobes.capture & strobes.first;
      eol      <= (strobes.capture & strobes.last) | strobes.abort;
      if (strobes.capture) pixOut <= pixData;
    end
  end

endmodule

// File: rtl/lineWindowCtrl.sv
`timescale 1ns/1ps
module lineWindowCtrl
  import lwc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SKIP_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lineValid,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] pixData,
  input  logic              armEn,
  input  logic              qualEn,
  input  logic [SKIP_W-1:0] skipCnt,
  input  logic [CNT_W-1:0]  activeCnt,
  output logic              pixValid,
  output logic [DATA_W-1:0] pixOut,
  output logic              sol,
  output logic              eol
);

  lwcStrobes_t strobes;

  lwcControl #(.SKIP_W(SKIP_W), .CNT_W(CNT_W)) u_control (
    .clk       (clk),
    .rst       (rst),
    .lineValid (lineValid),
    .dataValid (dataValid),
    .armEn     (armEn),
    .qualEn    (qualEn),
    .skipCnt   (skipCnt),
    .activeCnt (activeCnt),
    .strobes   (strobes)
  );

  lwcDatapath #(.DATA_W(DATA_W)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .pixData  (pixData),
    .pixValid (pixValid),
    .pixOut   (pixOut),
    .sol      (sol),
    .eol      (eol)
  );

endmodule

// File: rtl/lwcChecker.sv
`timescale 1ns/1ps
module lwcChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              lineValid,
  input logic              dataValid,
  input logic [DATA_W-1:0] pixData,
  input logic              armEn,
  input logic              qualEn,
  input logic              pixValid,
  input logic [DATA_W-1:0] pixOut,
  input logic              sol,
  input logic              eol
);

  logic lvSeen;
  logic edgeNow;

  always_ff @(posedge clk) begin
    if (rst) lvSeen <= 1'b0;
    else     lvSeen <= lineValid;
  end

  assign edgeNow = lineValid & ~lvSeen;

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!pixValid && !sol && !eol));

  assert_qualified_only_R5: assert property (@(posedge clk) disable iff (rst)
    pixValid |-> $past(!qualEn || dataValid));

  assert_data_latency_R6: assert property (@(posedge clk) disable iff (rst)
    pixValid |-> (pixOut == $past(pixData)));

  assert_sol_with_pixel_R7: assert property (@(posedge clk) disable iff (rst)
    sol |-> pixValid);

  assert_lone_eol_is_abort_R8: assert property (@(posedge clk) disable iff (rst)
    (eol && !pixValid) |-> $past(edgeNow));

  assert_unarmed_edge_R2: assert property (@(posedge clk) disable iff (rst)
    $past(edgeNow && !armEn) |-> !pixValid);

endmodule

bind lineWindowCtrl lwcChecker #(.DATA_W(DATA_W)) u_lwcChecker (.*);

// File: tb/test_lineWindowCtrl.sv
`timescale 1ns/1ps
module test_lineWindowCtrl;

  localparam int DATA_W = 8;
  localparam int SKIP_W = 8;
  localparam int CNT_W  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lineValid = 1'b0, dataValid = 1'b0, armEn = 1'b0, qualEn = 1'b0;
  logic [DATA_W-1:0] pixData = '0;
  logic [SKIP_W-1:0] skipCnt = '0;
  logic [CNT_W-1:0]  activeCnt = '0;
  logic pixValid, sol, eol;
  logic [DATA_W-1:0] pixOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  lineWindowCtrl #(.DATA_W(DATA_W), .SKIP_W(SKIP_W), .CNT_W(CNT_W)) i_lineWindowCtrl (
    .clk(clk), .rst(rst), .lineValid(lineValid), .dataValid(dataValid),
    .pixData(pixData), .armEn(armEn), .qualEn(qualEn), .skipCnt(skipCnt),
    .activeCnt(activeCnt), .pixValid(pixValid), .pixOut(pixOut), .sol(sol), .eol(eol)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive one clock's inputs on the falling edge, return after the next rising edge
  task automatic step(input logic lv, input logic dv, input logic arm, input logic [DATA_W-1:0] d);
    @(negedge clk);
    lineValid = lv; dataValid = dv; armEn = arm; pixData = d;
    @(posedge clk);
    #1;
  endtask

  // one line: expected outputs counted from qualified clocks since the edge
  task automatic runLine(input string req, input int skip, input int active, input logic qual,
                         input logic armAtRise, input int nHigh, input int nTotal,
                         input int dvMode, input logic abortPrev, input int base);
    int qc = 0;
    @(negedge clk);
    skipCnt = SKIP_W'(skip); activeCnt = CNT_W'(active); qualEn = qual;
    for (int i = 0; i < nTotal; i++) begin
      logic dv, q, expV, expS, expE;
      logic [DATA_W-1:0] d;
      dv = (dvMode == 0) ? 1'b1 : (dvMode == 1) ? ((i % 3) != 1) : ((i % 2) == 1);
      d  = DATA_W'(base + i);
      step(i < nHigh, dv, armAtRise ? 1'b1 : (i > 0), d);
      q    = !qual || dv;
      expV = armAtRise && q && (qc >= skip) && (qc < skip + active);
      expS = expV && (qc == skip);
      expE = (expV && (qc == skip + active - 1)) || (i == 0 && abortPrev);
      if (armAtRise && q) qc++;
      check({req, " pixValid"}, 32'(pixValid), 32'(expV));
      check({req, " sol R7"}, 32'(sol), 32'(expS));
      check({req, " eol R7"}, 32'(eol), 32'(expE));
      if (expV) check({req, " pixOut R6"}, 32'(pixOut), 32'(d));
    end
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) step(1'b0, 1'b0, 1'b1, '0);
    check("R11 pixValid", 32'(pixValid), 0);
    check("R11 sol", 32'(sol), 0);
    check("R11 eol", 32'(eol), 0);
    @(negedge clk); rst = 1'b0;
    step(1'b0, 1'b0, 1'b1, '0);
    check("R11 idle pixValid", 32'(pixValid), 0);
  endtask

  task automatic testBasic();
    runLine("R4 basic", 3, 5, 1'b0, 1'b1, 12, 15, 0, 1'b0, 8'h10);
  endtask

  task automatic testNoSkip();
    runLine("R3 skip0", 0, 4, 1'b0, 1'b1, 6, 8, 0, 1'b0, 8'h40);
  endtask

  task automatic testQualOn();
    runLine("R5 qual on", 2, 4, 1'b1, 1'b1, 12, 14, 1, 1'b0, 8'h60);
    runLine("R5 qual on alt", 1, 3, 1'b1, 1'b1, 10, 12, 2, 1'b0, 8'h70);
  endtask

  task automatic testQualOff();
    runLine("R5 qual off", 2, 4, 1'b0, 1'b1, 8, 10, 2, 1'b0, 8'h80);
  endtask

  task automatic testUnarmed();
    runLine("R2 unarmed", 0, 4, 1'b0, 1'b0, 6, 8, 0, 1'b0, 8'h90);
  endtask

  task automatic testZeroActive();
    runLine("R9 zero active skip0", 0, 0, 1'b0, 1'b1, 4, 6, 0, 1'b0, 8'hA0);
    runLine("R9 zero active skip2", 2, 0, 1'b0, 1'b1, 4, 6, 0, 1'b0, 8'hA8);
  endtask

  task automatic testFallIgnored();
    runLine("R1 fall ignored", 1, 5, 1'b0, 1'b1, 1, 8, 0, 1'b0, 8'hB0);
  endtask

  task automatic testMinPulse();
    runLine("R10 min pulse a", 0, 1, 1'b0, 1'b1, 1, 2, 0, 1'b0, 8'hC0);
    runLine("R10 min pulse b", 0, 1, 1'b0, 1'b1, 1, 2, 0, 1'b0, 8'hC4);
  endtask

  task automatic testAbort();
    runLine("R8 pre abort", 1, 6, 1'b0, 1'b1, 4, 5, 0, 1'b0, 8'hD0);
    runLine("R8 after abort", 2, 3, 1'b0, 1'b1, 6, 8, 0, 1'b1, 8'hE0);
  endtask

  task automatic testMaxSkip();
    runLine("R3 skip255", 255, 2, 1'b0, 1'b1, 258, 260, 0, 1'b0, 8'h00);
  endtask

  initial begin
    testReset();
    testBasic();
    testNoSkip();
    testQualOn();
    testQualOff();
    testUnarmed();
    testZeroActive();
    testFallIgnored();
    testMinPulse();
    testAbort();
    testMaxSkip();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule